// File: doc/BRIEF.md
# Dual-Tone Keypad Frequency Generator

This block produces the two tones of a telephone keypad digit as a stream of digital samples. A low-group tone and a high-group tone each come from a phase accumulator. The upper bits of each accumulator address a 32-point sine table. The two signed samples are added around mid-scale to give one unsigned output word. The word is refreshed at a fixed sample rate of 8 kHz. A one-cycle strobe marks each new word, and an analog stage further down the chain filters and converts it.

Software controls the block through three small write-only registers. The first holds the key code, which picks one of four row frequencies and one of four column frequencies. The second holds two independent enables, one per tone. The third holds a clock-rate code. This code sets the sample divider so the generated frequencies stay at their standard values across four system clock rates. A new key is taken up by a running tone only when its phase wraps, so the waveform never jumps mid-cycle.

Top module: `dtmf_keypad_gen`

## Requirements
- R1: After reset the key, enable and clock-rate registers are all 0. `tone_valid` is low, and `tone_out` holds mid-scale 128.
- R2: A sample update occurs every 64 << S clock cycles, where S is the 2-bit clock-rate code written at address 2 in bits [1:0]. Codes 0, 1, 2 and 3 suit 512 kHz, 1.024 MHz, 2.048 MHz and 4.096 MHz clocks for 8 kHz sampling.
- R3: For row index 0, 1, 2 and 3 the row phase advances per sample by round(f·65536/8000) for f = 697, 770, 852 and 941 Hz. These steps are 5710, 6308, 6980 and 7709 on a 16-bit accumulator.
- R4: For column index 0, 1, 2 and 3 the column phase advances per sample by the same rule for 1209, 1336, 1477 and 1633 Hz. These steps are 9904, 10945, 12100 and 13378.
- R5: Each enabled tone contributes sine[k], where k is the top 5 phase bits. The table is sine[k] = −sine[k−16] for k ≥ 16, and for k = 0..8 it gives 0, 12, 24, 35, 45, 52, 58, 62, 63, mirrored for k = 9..15. The output is 128 plus the two contributions, taken from the phases before they advance.
- R6: A disabled tone contributes 0 and its phase is held at 0. When it is enabled it starts from phase 0.
- R7: Address 1 bit 0 enables the row tone and bit 1 enables the column tone. Each enable works independently of the other.
- R8: At address 0, key bits [3:2] are the row index and bits [1:0] the column index. A running tone keeps its old index until a phase step carries out of 16 bits. That step still uses the old increment, and the new index applies from the next step. A disabled tone follows the key at once.
- R9: `tone_valid` is a one-cycle pulse coincident with each new `tone_out`, and `tone_out` holds between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 key, 1 enables, 2 clock-rate code |
| wr_data | input | 4 | Register write data |
| tone_out | output | 8 | Summed sample, offset binary around 128 |
| tone_valid | output | 1 | High for one cycle when `tone_out` updates |

## Verification
The bench runs its own phase model and compares every output word. A wrong increment, a lost carry or a phase not cleared on disable therefore shows as a mismatched word. This happens within a few samples, which is a few hundred clocks at the fastest rate. A key index taken early or late in the cycle shifts the wrap point, and the next sample that falls in a different table slot exposes it. Divider faults show as a wrong interval between strobes. The bench measures this interval directly for each clock-rate code.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
    localparam int LUT_BITS = 5;
    localparam int SAMP_W   = 8;

    typedef logic signed [SAMP_W-1:0] samp_t;

    // 32-point sine, amplitude 63, built from a quarter wave
    function automatic samp_t sine_at(input logic [LUT_BITS-1:0] k);
        logic [4:0] qi;
        samp_t      mag;
        qi = (k[3:0] <= 4'd8) ? {1'b0, k[3:0]} : (5'd16 - {1'b0, k[3:0]});
        case (qi)
            5'd0:    mag = 8'sd0;
            5'd1:    mag = 8'sd12;
            5'd2:    mag = 8'sd24;
            5'd3:    mag = 8'sd35;
            5'd4:    mag = 8'sd45;
            5'd5:    mag = 8'sd52;
            5'd6:    mag = 8'sd58;
            5'd7:    mag = 8'sd62;
            5'd8:    mag = 8'sd63;
            default: mag = 8'sd0;
        endcase
        return k[4] ? -mag : mag;
    endfunction

    function automatic int unsigned tone_hz(input bit is_col, input logic [1:0] idx);
        if (is_col) begin
            case (idx)
                2'd0: return 1209;
                2'd1: return 1336;
                2'd2: return 1477;
                default: return 1633;
            endcase
        end
        case (idx)
            2'd0: return 697;
            2'd1: return 770;
            2'd2: return 852;
            default: return 941;
        endcase
    endfunction

    function automatic longint unsigned phase_step(input int unsigned hz,
                                                   input int acc_w,
                                                   input int unsigned fs);
        return ((longint'(hz) << acc_w) + longint'(fs / 2)) / longint'(fs);
    endfunction
endpackage

// File: rtl/dtmf_tick_gen.sv
module dtmf_tick_gen #(
    parameter int BASE_DIV = 64,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] osc_sel,
    output logic             tick
);
    localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
    localparam int CNT_W   = $clog2(MAX_DIV);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim   = CNT_W'((BASE_DIV << osc_sel) - 1);
        tick  = (cnt_q >= lim);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
endmodule

// File: rtl/dtmf_tone_chan.sv
module dtmf_tone_chan
    import dtmf_pkg::*;
#(
    parameter int ACC_W     = 16,
    parameter int SAMPLE_HZ = 8000,
    parameter bit IS_COL    = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       enable,
    input  logic [1:0] key_idx,
    output samp_t      sample
);
    localparam logic [ACC_W-1:0] STEP0 = ACC_W'(phase_step(tone_hz(IS_COL, 2'd0), ACC_W, SAMPLE_HZ));
    localparam logic [ACC_W-1:0] STEP1 = ACC_W'(phase_step(tone_hz(IS_COL, 2'd1), ACC_W, SAMPLE_HZ));
    localparam logic [ACC_W-1:0] STEP2 = ACC_W'(phase_step(tone_hz(IS_COL, 2'd2), ACC_W, SAMPLE_HZ));
    localparam logic [ACC_W-1:0] STEP3 = ACC_W'(phase_step(tone_hz(IS_COL, 2'd3), ACC_W, SAMPLE_HZ));

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [1:0]       idx;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [ACC_W-1:0] step;
    logic             carry;
    logic [ACC_W-1:0] sum;

    always_comb begin
        case (st_q.idx)
            2'd0:    step = STEP0;
            2'd1:    step = STEP1;
            2'd2:    step = STEP2;
            default: step = STEP3;
        endcase
        {carry, sum} = {1'b0, st_q.acc} + {1'b0, step};
        st_d = st_q;
        if (!enable) begin
            st_d.acc = '0;
            st_d.idx = key_idx;
        end else if (tick) begin
            st_d.acc = sum;
            if (carry) st_d.idx = key_idx;
        end
        sample = enable ? sine_at(st_q.acc[ACC_W-1 -: LUT_BITS]) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> $stable(st_q.idx)); // R8
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> $stable(st_q.acc)); // R2
    AST_OFF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.acc == '0 && st_q.idx == $past(key_idx))); // R6
endmodule

// File: rtl/dtmf_keypad_gen.sv
module dtmf_keypad_gen
    import dtmf_pkg::*;
#(
    parameter int ACC_W     = 16,
    parameter int SAMPLE_HZ = 8000,
    parameter int BASE_DIV  = 64,
    parameter int OUT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [3:0]       wr_data,
    output logic [OUT_W-1:0] tone_out,
    output logic             tone_valid
);
    localparam int NUM_TONES = 2;
    localparam int MID       = 1 << (OUT_W - 1);

    typedef struct packed {
        logic [3:0]       key;
        logic [1:0]       en;
        logic [1:0]       sel;
        logic [OUT_W-1:0] out;
        logic             valid;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick;
    samp_t smp [NUM_TONES];
    int    total;

    dtmf_tick_gen #(.BASE_DIV(BASE_DIV), .SEL_W(2)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_sel (r_q.sel),
        .tick    (tick)
    );

    for (genvar g = 0; g < NUM_TONES; g++) begin : g_tone
        dtmf_tone_chan #(
            .ACC_W     (ACC_W),
            .SAMPLE_HZ (SAMPLE_HZ),
            .IS_COL    (g == 1)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .enable  (r_q.en[g]),
            .key_idx (g == 0 ? r_q.key[3:2] : r_q.key[1:0]),
            .sample  (smp[g])
        );
    end

    always_comb begin
        r_d       = r_q;
        total     = MID + int'(smp[0]) + int'(smp[1]);
        r_d.valid = tick;
        if (tick) r_d.out = OUT_W'(total);
        if (wr_en) begin
            case (wr_addr)
                2'd0:    r_d.key = wr_data;
                2'd1:    r_d.en  = wr_data[1:0];
                2'd2:    r_d.sel = wr_data[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.out <= OUT_W'(MID);
        end else begin
            r_q <= r_d;
        end
    end

    assign tone_out   = r_q.out;
    assign tone_valid = r_q.valid;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tone_valid |=> !tone_valid); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_valid |-> $stable(tone_out)); // R9
    AST_IDLE_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_valid && $past(r_q.en) == 2'b00) |-> tone_out == OUT_W'(MID)); // R6
    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_out >= OUT_W'(MID - 126)) && (tone_out <= OUT_W'(MID + 126))); // R5
endmodule

// File: tb/dtmf_keypad_gen_bench.sv
module dtmf_keypad_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic [7:0] tone_out;
    logic       tone_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int SINE [32] = '{0, 12, 24, 35, 45, 52, 58, 62, 63, 62, 58, 52, 45, 35, 24, 12,
                      0, -12, -24, -35, -45, -52, -58, -62, -63, -62, -58, -52, -45, -35, -24, -12};
    int STEPS [2][4] = '{'{5710, 6308, 6980, 7709}, '{9904, 10945, 12100, 13378}};

    // independent model of the tone state
    int       m_ph [2];
    int       m_idx [2];
    bit [1:0] m_en;
    bit [3:0] m_key;
    bit [1:0] m_sel;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dtmf_keypad_gen u_dtmf_keypad_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tone_out   (tone_out),
        .tone_valid (tone_valid)
    );

    function automatic int key_index(int g);
        return (g == 0) ? int'(m_key[3:2]) : int'(m_key[1:0]);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(bit [1:0] a, bit [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            2'd0: m_key = d;
            2'd1: m_en  = d[1:0];
            2'd2: m_sel = d[1:0];
            default: ;
        endcase
        for (int g = 0; g < 2; g++) begin
            if (!m_en[g]) begin
                m_ph[g]  = 0;
                m_idx[g] = key_index(g);
            end
        end
    endtask

    task automatic wait_valid(output int cycles);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (!tone_valid);
    endtask

    task automatic sample_check(string req);
        int cyc;
        int exp;
        int s;
        wait_valid(cyc);
        exp = 128;
        for (int g = 0; g < 2; g++)
            if (m_en[g]) exp += SINE[m_ph[g] >> 11];
        chk(int'(tone_out) == exp, req, int'(tone_out), exp);
        for (int g = 0; g < 2; g++) begin
            if (m_en[g]) begin
                s = m_ph[g] + STEPS[g][m_idx[g]];
                if (s >= 65536) m_idx[g] = key_index(g);
                m_ph[g] = s & 65535;
            end
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(tone_out == 8'd128, "R1 reset output", int'(tone_out), 128);
        chk(tone_valid == 1'b0, "R1 reset strobe", int'(tone_valid), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) sample_check("R1 tones off after reset");
    endtask

    task automatic t_row;
        for (int r = 0; r < 4; r++) begin
            wr(2'd1, 4'd0);
            wr(2'd0, 4'(r << 2));
            wr(2'd1, 4'd1);
            for (int i = 0; i < 20; i++) sample_check("R3 row frequency");
        end
    endtask

    task automatic t_col;
        for (int c = 0; c < 4; c++) begin
            wr(2'd1, 4'd0);
            wr(2'd0, 4'(c));
            wr(2'd1, 4'd2);
            for (int i = 0; i < 20; i++) sample_check("R4 column frequency");
        end
    endtask

    task automatic t_both;
        wr(2'd1, 4'd0);
        wr(2'd0, 4'b1001);
        wr(2'd1, 4'd3);
        for (int i = 0; i < 30; i++) sample_check("R5 summed output");
    endtask

    task automatic t_indep;
        wr(2'd1, 4'd2);
        for (int i = 0; i < 10; i++) sample_check("R7 row off column on");
        wr(2'd1, 4'd3);
        for (int i = 0; i < 10; i++) sample_check("R7 row restarts at phase 0");
    endtask

    task automatic t_wrap;
        wr(2'd1, 4'd0);
        wr(2'd0, 4'b0000);
        wr(2'd1, 4'd1);
        for (int i = 0; i < 5; i++) sample_check("R8 before key change");
        wr(2'd0, 4'b1100);
        for (int i = 0; i < 30; i++) sample_check("R8 key taken at wrap");
        wr(2'd0, 4'b0100);
        for (int i = 0; i < 12; i++) sample_check("R8 second key change");
    endtask

    task automatic t_off;
        wr(2'd1, 4'd0);
        for (int i = 0; i < 4; i++) sample_check("R6 both disabled mid-scale");
    endtask

    task automatic t_osc;
        int cyc;
        int hi;
        wr(2'd1, 4'd3);
        for (int s = 1; s < 4; s++) begin
            wr(2'd2, 4'(s));
            sample_check("R2 samples after rate change");
            wait_valid(cyc);
            // the model consumed no sample above; re-sync model by advancing it
            for (int g = 0; g < 2; g++) begin
                if (m_en[g]) begin
                    int v;
                    v = m_ph[g] + STEPS[g][m_idx[g]];
                    if (v >= 65536) m_idx[g] = key_index(g);
                    m_ph[g] = v & 65535;
                end
            end
            hi = 0;
            cyc = 0;
            do begin
                @(negedge clk);
                cyc++;
                if (tone_valid) hi++;
            end while (!tone_valid);
            chk(cyc == (64 << s), "R2 sample interval", cyc, 64 << s);
            chk(hi == 1, "R9 strobe width", hi, 1);
            for (int g = 0; g < 2; g++) begin
                if (m_en[g]) begin
                    int v;
                    v = m_ph[g] + STEPS[g][m_idx[g]];
                    if (v >= 65536) m_idx[g] = key_index(g);
                    m_ph[g] = v & 65535;
                end
            end
            sample_check("R2 samples at new rate");
        end
        wr(2'd2, 4'd0);
        sample_check("R2 back to base rate");
        wait_valid(cyc);
        for (int g = 0; g < 2; g++) begin
            if (m_en[g]) begin
                int v;
                v = m_ph[g] + STEPS[g][m_idx[g]];
                if (v >= 65536) m_idx[g] = key_index(g);
                m_ph[g] = v & 65535;
            end
        end
        sample_check("R2 base rate");
    endtask

    task automatic t_hold;
        logic [7:0] held;
        int cyc;
        bit stable;
        sample_check("R9 new word");
        held = tone_out;
        stable = 1'b1;
        cyc = 0;
        @(negedge clk);
        while (!tone_valid) begin
            if (tone_out != held) stable = 1'b0;
            cyc++;
            @(negedge clk);
        end
        chk(stable, "R9 output held between strobes", int'(stable), 1);
        chk(cyc == 63, "R2 base interval", cyc + 1, 64);
    endtask

    initial begin
        m_ph = '{0, 0};
        m_idx = '{0, 0};
        m_en = '0; m_key = '0; m_sel = '0;
        t_reset;
        t_row;
        t_col;
        t_both;
        t_indep;
        t_wrap;
        t_off;
        t_osc;
        t_hold;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog expired actual %0d expected %0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule